// File: doc/BRIEF.md
# Inter-Processor Mailbox

This block lets processors that share a chip exchange 32-bit messages. Each mailbox is a small one-way hardware queue. A sender writes a word into the mailbox's message register, and the receiver reads the same register to take the oldest word out. Mailboxes are normally used in pairs, one for each direction: mailbox 0 carries host-to-peer traffic and mailbox 1 carries peer-to-host traffic.

Each mailbox has a full-flag register and a message-count register. Each mailbox can raise two events. A "new message" event fires when a word is accepted. A "not full" event fires when a word is taken from a full queue. Every user has its own pair of status and enable registers. The status register is write-one-to-clear, and a user's interrupt line is raised while any event is both pending and enabled.

The block also has a fixed revision register, a configuration register with a self-clearing soft-reset bit, and a status register with a reset-done flag. All registers are on a simple 32-bit bus with separate read and write strobes. Read data is combinational on the address. A read strobe on a message register pops the queue at the next clock edge.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every queue is empty, every full flag, count, enable and status register reads 0, `irq_out` is 0, and the reset-done flag (bit 0 at 0x014) reads 1.
- R2: The register at 0x000 reads the revision: major number in bits 7:4, minor number in bits 3:0, and zero above. The default value is 0x20.
- R3: A write to 0x040+4m appends the word to queue m. A read of the same address returns the oldest word and removes it. A read of an empty queue returns 0 and leaves the count unchanged. Traffic on one queue does not change any other queue.
- R4: A write to a full queue (DEPTH words) is discarded. The register at 0x080+4m reads 1 while queue m is full and 0 otherwise.
- R5: The register at 0x0C0+4m reads the number of words held in queue m.
- R6: An accepted write to queue m sets bit 2m of every user's status register (0x100+8u). A discarded write sets nothing.
- R7: Removing a word from a full queue m sets bit 2m+1 of every user's status register.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: The register at 0x104+8u holds user u's enables in bits 2*NUM_BOX-1:0, and higher bits read 0. `irq_out[u]` is 1 exactly while some bit is set in both enable and status, and it follows a register change by one clock.
- R10: Writing 1 to bit 1 of 0x010 starts a soft reset that lasts RST_CYCLES clocks. During this time, bit 1 of 0x010 reads 1, the reset-done flag reads 0, all queues, enables and status bits are cleared, and writes to them are ignored. Afterwards, bit 1 reads 0 and reset-done reads 1.
- R11: A read of an address that no register uses returns 0, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe; pops a queue when the address is a message register |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (9) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| irq_out | output | NUM_USER (2) | One interrupt line per user |

## Verification
The first test writes two words to a queue and reads three. This separates correct first-in-first-out order from reversed order, and shows that a read of an empty queue returns zero. The second test writes one word more than the queue holds. This separates a discarded overflow from an overwrite, and the full flag and the not-full event are checked on the pop that follows. Status clears are tried with an all-zero write and with a one-bit write, which separates write-one-to-clear from plain write. The enable register is written with a single bit and then with all ones, which shows the effect of each user's mask on `irq_out`. A soft reset is started while words and events are pending, and a write is made during the reset window, to show that state is cleared and that writes are blocked until the reset ends.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    // Register offsets: software decodes these, so they are fixed.
    localparam int OFS_REV    = 'h000;
    localparam int OFS_CFG    = 'h010;
    localparam int OFS_STAT   = 'h014;
    localparam int OFS_MSG    = 'h040;
    localparam int OFS_FULL   = 'h080;
    localparam int OFS_COUNT  = 'h0C0;
    localparam int OFS_IRQ    = 'h100;
    localparam int IRQ_STRIDE = 8;
    localparam int IRQ_EN_OFS = 4;
    localparam int CFG_RST_BIT = 1;

    function automatic logic [31:0] rev_word(input int major, input int minor);
        rev_word = {24'h0, 4'(major), 4'(minor)};
    endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          push_ok,
    output logic          nf_evt
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic     pop_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        nxt = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (s_q.cnt == CW'(DEPTH));
    assign count = s_q.cnt;
    assign head  = (s_q.cnt == '0) ? '0 : s_q.mem[s_q.rp];

    always_comb begin
        s_d     = s_q;
        push_ok = push && !full && !clr;
        pop_ok  = pop && (s_q.cnt != '0) && !clr;
        nf_evt  = pop_ok && full;
        if (push_ok) begin
            s_d.mem[s_q.wp] = wdata;
            s_d.wp          = nxt(s_q.wp);
        end
        if (pop_ok) s_d.rp = nxt(s_q.rp);
        if (push_ok && !pop_ok)      s_d.cnt = s_q.cnt + 1'b1;
        else if (pop_ok && !push_ok) s_d.cnt = s_q.cnt - 1'b1;
        if (clr) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4
    push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == $past(count)));
    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0 && !push && !clr) |=> (count == '0 && $stable(s_q.rp)));
    // R10
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
    parameter int NE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [NE-1:0] evt,
    input  logic          en_we,
    input  logic          st_we,
    input  logic [NE-1:0] wdata,
    output logic [NE-1:0] en,
    output logic [NE-1:0] st,
    output logic          irq
);
    typedef struct packed {
        logic [NE-1:0] en;
        logic [NE-1:0] st;
    } irq_st_t;

    irq_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en_we) s_d.en = wdata;
        s_d.st = (s_q.st & ~(st_we ? wdata : '0)) | evt;
        if (clr) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en  = s_q.en;
    assign st  = s_q.st;
    assign irq = |(s_q.en & s_q.st);

    // R6 R7
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|evt) && !clr) |=> ((st & $past(evt)) == $past(evt)));
    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !clr && evt == '0) |=> (st == ($past(st) & ~$past(wdata))));
endmodule

// File: rtl/mbox_swrst.sv
module mbox_swrst #(
    parameter int RST_CYCLES = 3,
    localparam int RW = $clog2(RST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    typedef struct packed {
        logic [RW-1:0] cnt;
    } rst_st_t;

    rst_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start)                s_d.cnt = RW'(RST_CYCLES);
        else if (s_q.cnt != '0)   s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = (s_q.cnt != '0);

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbox_pkg::*;
#(
    parameter int NUM_BOX    = 4,
    parameter int NUM_USER   = 2,
    parameter int DEPTH      = 4,
    parameter int RST_CYCLES = 3,
    parameter int REV_MAJOR  = 2,
    parameter int REV_MINOR  = 0,
    parameter int AW         = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [AW-1:0]       bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_USER-1:0] irq_out
);
    localparam int NE = 2 * NUM_BOX;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [31:0] REV_VAL = rev_word(REV_MAJOR, REV_MINOR);

    logic [31:0]        head_v  [NUM_BOX];
    logic [CW-1:0]      count_v [NUM_BOX];
    logic [NUM_BOX-1:0] full_v, push_v, pop_v, push_ok_v, nf_v;
    logic [NE-1:0]      evt;
    logic [NE-1:0]      en_v [NUM_USER];
    logic [NE-1:0]      st_v [NUM_USER];
    logic [NUM_USER-1:0] en_we_v, st_we_v;
    logic               rst_start, rst_busy;

    assign rst_start = bus_wr && (bus_addr == AW'(OFS_CFG)) && bus_wdata[CFG_RST_BIT];

    mbox_swrst #(.RST_CYCLES(RST_CYCLES)) u_swrst (
        .clk(clk), .rst_n(rst_n), .start(rst_start), .busy(rst_busy)
    );

    for (genvar m = 0; m < NUM_BOX; m++) begin : g_box
        assign push_v[m] = bus_wr && (bus_addr == AW'(OFS_MSG + 4 * m));
        assign pop_v[m]  = bus_rd && (bus_addr == AW'(OFS_MSG + 4 * m));
        assign evt[2*m]   = push_ok_v[m];
        assign evt[2*m+1] = nf_v[m];

        mbox_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n), .clr(rst_busy),
            .push(push_v[m]), .pop(pop_v[m]), .wdata(bus_wdata),
            .head(head_v[m]), .count(count_v[m]), .full(full_v[m]),
            .push_ok(push_ok_v[m]), .nf_evt(nf_v[m])
        );
    end

    for (genvar u = 0; u < NUM_USER; u++) begin : g_user
        assign st_we_v[u] = bus_wr && (bus_addr == AW'(OFS_IRQ + IRQ_STRIDE * u));
        assign en_we_v[u] = bus_wr && (bus_addr == AW'(OFS_IRQ + IRQ_STRIDE * u + IRQ_EN_OFS));

        mbox_irq #(.NE(NE)) u_irq (
            .clk(clk), .rst_n(rst_n), .clr(rst_busy), .evt(evt),
            .en_we(en_we_v[u]), .st_we(st_we_v[u]), .wdata(bus_wdata[NE-1:0]),
            .en(en_v[u]), .st(st_v[u]), .irq(irq_out[u])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFS_REV))  bus_rdata = REV_VAL;
        if (bus_addr == AW'(OFS_CFG))  bus_rdata = 32'(rst_busy) << CFG_RST_BIT;
        if (bus_addr == AW'(OFS_STAT)) bus_rdata = 32'(!rst_busy);
        for (int m = 0; m < NUM_BOX; m++) begin
            if (bus_addr == AW'(OFS_MSG + 4 * m))   bus_rdata = head_v[m];
            if (bus_addr == AW'(OFS_FULL + 4 * m))  bus_rdata = 32'(full_v[m]);
            if (bus_addr == AW'(OFS_COUNT + 4 * m)) bus_rdata = 32'(count_v[m]);
        end
        for (int u = 0; u < NUM_USER; u++) begin
            if (bus_addr == AW'(OFS_IRQ + IRQ_STRIDE * u))              bus_rdata = 32'(st_v[u]);
            if (bus_addr == AW'(OFS_IRQ + IRQ_STRIDE * u + IRQ_EN_OFS)) bus_rdata = 32'(en_v[u]);
        end
    end

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy |=> (irq_out == '0));
endmodule

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/1ps
module sim_ipc_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ipc_mailbox u0 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        is_rd;
        logic [8:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 9'h000, 32'h0, 32'h20, 4'd2},   // R2 revision
        '{1'b1, 9'h014, 32'h0, 32'h1,  4'd1},   // R1 reset done
        '{1'b1, 9'h0C0, 32'h0, 32'h0,  4'd1},
        '{1'b0, 9'h040, 32'hA1, 32'h0, 4'd0},
        '{1'b0, 9'h040, 32'hA2, 32'h0, 4'd0},
        '{1'b1, 9'h0C0, 32'h0, 32'h2,  4'd5},   // R5 count
        '{1'b1, 9'h0C4, 32'h0, 32'h0,  4'd3},   // R3 other box untouched
        '{1'b1, 9'h100, 32'h0, 32'h1,  4'd6},   // R6 user0 new msg bit0
        '{1'b1, 9'h108, 32'h0, 32'h1,  4'd6},   // R6 user1 too
        '{1'b1, 9'h040, 32'h0, 32'hA1, 4'd3},   // R3 oldest first
        '{1'b1, 9'h040, 32'h0, 32'hA2, 4'd3},
        '{1'b1, 9'h040, 32'h0, 32'h0,  4'd3},   // R3 empty read
        '{1'b1, 9'h0C0, 32'h0, 32'h0,  4'd3},
        '{1'b0, 9'h100, 32'h0, 32'h0,  4'd0},
        '{1'b1, 9'h100, 32'h0, 32'h1,  4'd8},   // R8 zero write keeps
        '{1'b0, 9'h100, 32'h1, 32'h0,  4'd0},
        '{1'b1, 9'h100, 32'h0, 32'h0,  4'd8},   // R8 one clears
        '{1'b1, 9'h1F0, 32'h0, 32'h0,  4'd11}   // R11 unmapped
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [8:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check("R1 irq_out after reset", 32'(irq_out), 32'h0);
        rd_chk("R1 full flag box0", 9'h080, 32'h0);
        rd_chk("R1 enable user0", 9'h104, 32'h0);
        rd_chk("R1 config", 9'h010, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) begin
                logic [31:0] v;
                rd(VECS[i].a, v);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
            end else begin
                wr(VECS[i].a, VECS[i].d);
            end
        end

        // R4: overfill box2 by one word
        for (int k = 0; k < 5; k++) wr(9'h048, 32'h10 + k);
        rd_chk("R4 full flag", 9'h088, 32'h1);
        rd_chk("R5 count at full", 9'h0C8, 32'h4);
        rd_chk("R6 new msg box2 only", 9'h100, 32'h10);
        rd_chk("R3 pop from full", 9'h048, 32'h10);
        rd_chk("R7 not-full event", 9'h100, 32'h30);
        rd_chk("R4 flag drops", 9'h088, 32'h0);
        rd_chk("R3 order 2", 9'h048, 32'h11);
        rd_chk("R3 order 3", 9'h048, 32'h12);
        rd_chk("R3 order 4", 9'h048, 32'h13);
        rd_chk("R4 overflow word discarded", 9'h048, 32'h0);

        // R9 enables and irq lines
        #1 check("R9 no enable no irq", 32'(irq_out), 32'h0);
        wr(9'h104, 32'h20);
        rd_chk("R9 enable readback", 9'h104, 32'h20);
        #1 check("R9 irq user0", 32'(irq_out), 32'h1);
        wr(9'h104, 32'hFFFF_FFFF);
        rd_chk("R9 enable width", 9'h104, 32'hFF);
        wr(9'h10C, 32'h01);
        #1 check("R9 irq both", 32'(irq_out), 32'h3);
        wr(9'h100, 32'h30);
        #1 check("R8 clear drops irq0", 32'(irq_out), 32'h2);
        rd_chk("R6 user1 unaffected", 9'h108, 32'h31);
        wr(9'h1F0, 32'hFFFF_FFFF);
        rd_chk("R11 write ignored", 9'h108, 32'h31);

        // R10 soft reset with pending state
        wr(9'h044, 32'h5);
        wr(9'h010, 32'h2);
        rd_chk("R10 config bit set", 9'h010, 32'h2);
        rd_chk("R10 done low", 9'h014, 32'h0);
        wr(9'h044, 32'h7);
        rd_chk("R10 done high", 9'h014, 32'h1);
        rd_chk("R10 config self-clear", 9'h010, 32'h0);
        rd_chk("R10 queue emptied", 9'h0C4, 32'h0);
        rd_chk("R10 status cleared", 9'h108, 32'h0);
        rd_chk("R10 enable cleared", 9'h10C, 32'h0);
        #1 check("R10 irq low", 32'(irq_out), 32'h0);

        finish_run();
    end
endmodule